// File: doc/BRIEF.md
# PLL Reconfiguration Control Sequencer

This block sits between a register bus and an analog fractional-N PLL. Software reaches the PLL control bits, the staged divider settings and a status word through a small memory-mapped port. It can then start one of three commands: bring-up, retune or power-off. The block drives power-up, bypass-mux, output-enable and a hardware-control select toward the PLL. It also presents the active divider fields, which change only while the PLL is powered down during a retune.

A retune walks a fixed order. It releases hardware control, gates the output, powers down and drops bypass. It then copies the staged dividers to the PLL and waits a settle time counted in microseconds. After that it powers up, waits for lock and reopens the output. A bring-up raises bypass, power and output in turn, waits for lock, and then releases bypass. Every lock wait is bounded by a microsecond timeout. An expired wait raises a sticky error and returns the sequencer to idle. Microsecond timing comes from a prescaler whose parameter is the system clock frequency in MHz. A generate option selects fractional or integer operation. In integer mode the fractional words are never forwarded to the PLL.

Top module: `pllseq_top`

## Requirements
- R1: After reset every PLL-facing output is 0, and the control, divider, numerator, denominator and status words read back 0 while lock is low.
- R2: The control word at 0x00 holds power-up in bit 0, output enable in bit 1, bypass in bit 2 and hardware-control select in bit 16. All other bits read 0. While idle, a write to this word drives the four matching outputs from the next cycle.
- R3: The divider word at 0x60 stages the integer multiplier in bits 24:16, the reference divider in bits 15:13 and the output divider in bits 7:0. The numerator word at 0x40 stages a 30-bit value in bits 31:2, and the denominator word at 0x50 stages a 30-bit value in bits 29:0. Writing these words never changes the PLL-facing divider outputs; only a retune copies them there.
- R4: The status word at 0xF0 shows lock in bit 0, busy in bit 1 and timeout error in bit 2. A write to 0x04 issues commands: bit 0 bring-up, bit 1 retune, bit 2 power-off. When several bits are set, retune wins over bring-up, and bring-up wins over power-off.
- R5: A retune clears hardware select, output enable, power-up and bypass on four successive cycles, in that order. On the next cycle it copies the staged fields to the divider outputs, with power-up low.
- R6: Power-up rises exactly SETTLE_US*CLK_MHZ+1 cycles after the divider outputs change.
- R7: Once lock is seen, a retune sets output enable within two cycles and then returns to idle, with bypass and hardware select low.
- R8: If lock is not seen within LOCK_TO_US microseconds of power-up, the timeout error is set and busy clears with output enable still low. The whole retune then lasts 6+(SETTLE_US+LOCK_TO_US)*CLK_MHZ cycles.
- R9: With power-up low, bring-up sets bypass, then power-up, then output enable on successive cycles, waits for lock, and then clears bypass. With power-up already high it does nothing and never shows busy. Starting a bring-up or a retune clears the timeout error.
- R10: Power-off clears power-up in the next cycle and leaves every other control bit unchanged.
- R11: In integer mode (FRAC_MODE=0) a retune loads only the divider fields. The numerator and denominator outputs stay 0.
- R12: While busy, writes to the control and divider words and all commands are ignored. Numerator and denominator writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_pwrup | output | 1 | PLL power-up |
| pll_outen | output | 1 | PLL output mux enable |
| pll_bypass | output | 1 | PLL bypass mux select |
| pll_hwsel | output | 1 | Hardware-control select |
| pll_mfi | output | 9 | Active integer multiplier |
| pll_rdiv | output | 3 | Active reference divider |
| pll_odiv | output | 8 | Active output divider |
| pll_mfn | output | 30 | Active fractional numerator |
| pll_mfd | output | 30 | Active fractional denominator |

## Verification
The bus and the sequencer both write the control word, so a software write can arrive in a cycle where the sequencer is also updating that word. It can also arrive while the sequencer is parked in its lock wait. The bench provokes this by issuing control, divider and power-off writes during a retune's lock wait, and one numerator write in the same window. It then judges at the ports that power-up stays high and the control and divider readbacks are unchanged. The numerator readback must take the new value, and the active numerator must change only at the next retune's load step.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_CMD  = 8'h04;
   localparam logic [7:0] A_NUM  = 8'h40;
   localparam logic [7:0] A_DEN  = 8'h50;
   localparam logic [7:0] A_DIV  = 8'h60;
   localparam logic [7:0] A_STAT = 8'hF0;

   localparam int unsigned MFI_W  = 9;
   localparam int unsigned RDIV_W = 3;
   localparam int unsigned ODIV_W = 8;
   localparam int unsigned FRAC_W = 30;

   typedef struct packed {
      logic hwsel;
      logic bypass;
      logic outen;
      logic pwrup;
   } ctrl_t;

   typedef enum logic [3:0] {
      S_IDLE, S_HWOFF, S_OUTOFF, S_PWROFF, S_BYPOFF, S_LOAD, S_SETTLE,
      S_PWRON, S_LOCK, S_OUTON, S_PBYP, S_PPWR, S_POUT, S_PBYPCLR
   } seq_state_e;
endpackage

// File: rtl/pllseq_ustick.sv
module pllseq_ustick #(
   parameter int unsigned CLK_MHZ = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (CLK_MHZ < 1) begin : g_bad
         $error("pllseq_ustick: CLK_MHZ must be at least 1");
      end
      if (CLK_MHZ == 1) begin : g_direct
         assign tick = !clr;
      end else begin : g_count
         localparam int unsigned PW = $clog2(CLK_MHZ);
         logic [PW-1:0] pre_q;
         wire           wrap = (pre_q == PW'(CLK_MHZ - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre_q <= '0;
            else if (clr || wrap)  pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
         end
         assign tick = wrap && !clr;
      end
   endgenerate
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
   import pllseq_pkg::*;
#(
   parameter int unsigned SETTLE_US  = 5,
   parameter int unsigned LOCK_TO_US = 200
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmd_prep,
   input  logic  cmd_retune,
   input  logic  cmd_unprep,
   input  logic  pwr_now,
   input  logic  lock,
   input  logic  us_tick,
   output logic  us_clr,
   output ctrl_t set_m,
   output ctrl_t clr_m,
   output logic  load_div,
   output logic  busy,
   output logic  err_set,
   output logic  err_clr
);
   localparam int unsigned MAXUS = (SETTLE_US > LOCK_TO_US) ? SETTLE_US : LOCK_TO_US;
   localparam int unsigned CW    = $clog2(MAXUS + 1);

   generate
      if (SETTLE_US < 1 || LOCK_TO_US < 1) begin : g_bad
         $error("pllseq_fsm: delays must be at least one microsecond");
      end
   endgenerate

   seq_state_e state_q, state_d;
   logic       prep_mode_q, prep_mode_d;
   logic [CW-1:0] us_q;

   wire settle_done = us_tick && (us_q == CW'(SETTLE_US - 1));
   wire lock_expire = us_tick && (us_q == CW'(LOCK_TO_US - 1));

   always_comb begin
      state_d     = state_q;
      prep_mode_d = prep_mode_q;
      set_m       = '0;
      clr_m       = '0;
      load_div    = 1'b0;
      us_clr      = 1'b0;
      err_set     = 1'b0;
      err_clr     = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (cmd_retune) begin
               state_d = S_HWOFF;  prep_mode_d = 1'b0; err_clr = 1'b1;
            end else if (cmd_prep) begin
               if (!pwr_now) begin
                  state_d = S_PBYP; prep_mode_d = 1'b1; err_clr = 1'b1;
               end
            end else if (cmd_unprep) begin
               clr_m.pwrup = 1'b1;
            end
         end
         S_HWOFF:  begin clr_m.hwsel  = 1'b1; state_d = S_OUTOFF; end
         S_OUTOFF: begin clr_m.outen  = 1'b1; state_d = S_PWROFF; end
         S_PWROFF: begin clr_m.pwrup  = 1'b1; state_d = S_BYPOFF; end
         S_BYPOFF: begin clr_m.bypass = 1'b1; state_d = S_LOAD;   end
         S_LOAD:   begin load_div = 1'b1; us_clr = 1'b1; state_d = S_SETTLE; end
         S_SETTLE: if (settle_done) state_d = S_PWRON;
         S_PWRON:  begin set_m.pwrup = 1'b1; us_clr = 1'b1; state_d = S_LOCK; end
         S_LOCK: begin
            if (lock)             state_d = prep_mode_q ? S_PBYPCLR : S_OUTON;
            else if (lock_expire) begin err_set = 1'b1; state_d = S_IDLE; end
         end
         S_OUTON:   begin set_m.outen  = 1'b1; state_d = S_IDLE; end
         S_PBYP:    begin set_m.bypass = 1'b1; state_d = S_PPWR; end
         S_PPWR:    begin set_m.pwrup  = 1'b1; state_d = S_POUT; end
         S_POUT:    begin set_m.outen  = 1'b1; us_clr = 1'b1; state_d = S_LOCK; end
         S_PBYPCLR: begin clr_m.bypass = 1'b1; state_d = S_IDLE; end
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         prep_mode_q <= 1'b0;
         us_q        <= '0;
      end else begin
         state_q     <= state_d;
         prep_mode_q <= prep_mode_d;
         if (us_clr)       us_q <= '0;
         else if (us_tick) us_q <= us_q + 1'b1;
      end
   end

   assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
   import pllseq_pkg::*;
#(
   parameter int unsigned CLK_MHZ    = 125,
   parameter int unsigned SETTLE_US  = 5,
   parameter int unsigned LOCK_TO_US = 200,
   parameter bit          FRAC_MODE  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic        bus_wen,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        pll_lock,
   output logic        pll_pwrup,
   output logic        pll_outen,
   output logic        pll_bypass,
   output logic        pll_hwsel,
   output logic [8:0]  pll_mfi,
   output logic [2:0]  pll_rdiv,
   output logic [7:0]  pll_odiv,
   output logic [29:0] pll_mfn,
   output logic [29:0] pll_mfd
);
   ctrl_t             ctrl_q, set_m, clr_m;
   logic [MFI_W-1:0]  st_mfi, act_mfi;
   logic [RDIV_W-1:0] st_rdiv, act_rdiv;
   logic [ODIV_W-1:0] st_odiv, act_odiv;
   logic [FRAC_W-1:0] st_mfn, st_mfd;
   logic              err_q, seq_busy, us_clr, us_tick, load_div, err_set, err_clr;

   wire wr_ctrl = bus_wen && bus_addr == A_CTRL && !seq_busy;
   wire wr_div  = bus_wen && bus_addr == A_DIV  && !seq_busy;
   wire wr_num  = bus_wen && bus_addr == A_NUM;
   wire wr_den  = bus_wen && bus_addr == A_DEN;
   wire wr_cmd  = bus_wen && bus_addr == A_CMD;

   pllseq_ustick #(.CLK_MHZ(CLK_MHZ)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(us_clr), .tick(us_tick));

   pllseq_fsm #(.SETTLE_US(SETTLE_US), .LOCK_TO_US(LOCK_TO_US)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_prep(wr_cmd && bus_wdata[0]), .cmd_retune(wr_cmd && bus_wdata[1]),
      .cmd_unprep(wr_cmd && bus_wdata[2]), .pwr_now(ctrl_q.pwrup),
      .lock(pll_lock), .us_tick(us_tick), .us_clr(us_clr),
      .set_m(set_m), .clr_m(clr_m), .load_div(load_div), .busy(seq_busy),
      .err_set(err_set), .err_clr(err_clr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         err_q   <= 1'b0;
         st_mfi  <= '0; st_rdiv <= '0; st_odiv <= '0;
         st_mfn  <= '0; st_mfd  <= '0;
         act_mfi <= '0; act_rdiv <= '0; act_odiv <= '0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= ctrl_t'{hwsel: bus_wdata[16], bypass: bus_wdata[2],
                              outen: bus_wdata[1], pwrup: bus_wdata[0]};
         else
            ctrl_q <= ctrl_t'((ctrl_q & ~clr_m) | set_m);
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         if (wr_div) begin
            st_mfi  <= bus_wdata[24:16];
            st_rdiv <= bus_wdata[15:13];
            st_odiv <= bus_wdata[7:0];
         end
         if (wr_num) st_mfn <= bus_wdata[31:2];
         if (wr_den) st_mfd <= bus_wdata[29:0];
         if (load_div) begin
            act_mfi  <= st_mfi;
            act_rdiv <= st_rdiv;
            act_odiv <= st_odiv;
         end
      end
   end

   generate
      if (FRAC_MODE) begin : g_frac
         logic [FRAC_W-1:0] act_mfn, act_mfd;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_mfn <= '0;
               act_mfd <= '0;
            end else if (load_div) begin
               act_mfn <= st_mfn;
               act_mfd <= st_mfd;
            end
         end
         assign pll_mfn = act_mfn;
         assign pll_mfd = act_mfd;
      end else begin : g_int
         assign pll_mfn = '0;
         assign pll_mfd = '0;
      end
   endgenerate

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = {15'b0, ctrl_q.hwsel, 13'b0, ctrl_q.bypass,
                               ctrl_q.outen, ctrl_q.pwrup};
         A_NUM:   bus_rdata = {st_mfn, 2'b0};
         A_DEN:   bus_rdata = {2'b0, st_mfd};
         A_DIV:   bus_rdata = {7'b0, st_mfi, st_rdiv, 5'b0, st_odiv};
         A_STAT:  bus_rdata = {29'b0, err_q, seq_busy, pll_lock};
         default: bus_rdata = '0;
      endcase
   end

   assign pll_pwrup  = ctrl_q.pwrup;
   assign pll_outen  = ctrl_q.outen;
   assign pll_bypass = ctrl_q.bypass;
   assign pll_hwsel  = ctrl_q.hwsel;
   assign pll_mfi    = act_mfi;
   assign pll_rdiv   = act_rdiv;
   assign pll_odiv   = act_odiv;
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk
   import pllseq_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] bus_addr,
   input logic       bus_wen,
   input logic [2:0] cmd_bits,
   input logic       busy,
   input logic       err,
   input logic [8:0] st_mfi,
   input logic [8:0] pll_mfi,
   input logic [7:0] pll_odiv,
   input logic       pll_pwrup,
   input logic       pll_outen
);
   a_r12_div_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wen && bus_addr == A_DIV) |=> $stable(st_mfi));

   a_r5_load_while_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_mfi != $past(pll_mfi) || pll_odiv != $past(pll_odiv)) |-> !pll_pwrup);

   a_r8_error_ends_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy);

   a_r10_poweroff_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && bus_wen && bus_addr == A_CMD && cmd_bits == 3'b100) |=> !pll_pwrup);

   a_r7_outen_after_power: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pll_outen) && $past(busy)) |-> pll_pwrup);
endmodule

bind pllseq_top pllseq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
   .cmd_bits(bus_wdata[2:0]), .busy(seq_busy), .err(err_q), .st_mfi(st_mfi),
   .pll_mfi(pll_mfi), .pll_odiv(pll_odiv), .pll_pwrup(pll_pwrup),
   .pll_outen(pll_outen));

// File: tb/pllseq_top_tb.sv
module pllseq_top_tb_top;
   localparam int MHZ = 4, SET = 5, TO = 200;
   localparam int SN = SET * MHZ, TN = TO * MHZ;
   localparam logic [7:0] A_CTRL = 8'h00, A_CMD = 8'h04, A_NUM = 8'h40,
                          A_DEN = 8'h50, A_DIV = 8'h60, A_STAT = 8'hF0;
   localparam logic [31:0] DIVV = (32'd162 << 16) | (32'd1 << 13) | 32'd6;

   logic clk = 1'b0, rst_n = 1'b0, bus_wen = 1'b0, lock = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0, rdata, rdata_int;
   logic pwr, oen, byp, hws, pwr_i, oen_i, byp_i, hws_i;
   logic [8:0] mfi, mfi_i;
   logic [2:0] rdv, rdv_i;
   logic [7:0] odv, odv_i;
   logic [29:0] mfn, mfd, mfn_i, mfd_i;
   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   pllseq_top #(.CLK_MHZ(MHZ), .SETTLE_US(SET), .LOCK_TO_US(TO), .FRAC_MODE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(rdata), .pll_lock(lock),
      .pll_pwrup(pwr), .pll_outen(oen), .pll_bypass(byp), .pll_hwsel(hws),
      .pll_mfi(mfi), .pll_rdiv(rdv), .pll_odiv(odv), .pll_mfn(mfn), .pll_mfd(mfd));

   pllseq_top #(.CLK_MHZ(MHZ), .SETTLE_US(SET), .LOCK_TO_US(TO), .FRAC_MODE(1'b0)) dut_int_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_int), .pll_lock(lock),
      .pll_pwrup(pwr_i), .pll_outen(oen_i), .pll_bypass(byp_i), .pll_hwsel(hws_i),
      .pll_mfi(mfi_i), .pll_rdiv(rdv_i), .pll_odiv(odv_i), .pll_mfn(mfn_i), .pll_mfd(mfd_i));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] outs();
      return {15'b0, hws, 13'b0, byp, oen, pwr};
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1", "outputs", outs(), 32'h0);
      chk("R1", "dividers", {mfi, rdv, odv}, 32'h0);
      chk("R1", "fractions", mfn | mfd, 32'h0);
      rd(A_CTRL, v); chk("R1", "ctrl rd", v, 32'h0);
      rd(A_DIV, v);  chk("R1", "div rd", v, 32'h0);
      rd(A_STAT, v); chk("R1", "status rd", v, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_CTRL, 32'hFFFF_FFFF);
      chk("R2", "ctrl outputs", outs(), 32'h0001_0007);
      rd(A_CTRL, v); chk("R2", "ctrl rd mask", v, 32'h0001_0007);
      wr(A_CTRL, 32'h0000_0002);
      chk("R2", "ctrl outen only", outs(), 32'h0000_0002);
      wr(A_CTRL, 32'h0);
      wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, v); chk("R3", "div rd mask", v, 32'h01FF_E0FF);
      wr(A_NUM, 32'hFFFF_FFFF); rd(A_NUM, v); chk("R3", "num rd mask", v, 32'hFFFF_FFFC);
      wr(A_DEN, 32'hFFFF_FFFF); rd(A_DEN, v); chk("R3", "den rd mask", v, 32'h3FFF_FFFF);
      chk("R3", "staging not forwarded", {mfi, odv} | mfn, 32'h0);
   endtask

   task automatic t_retune_ok();
      logic [31:0] v;
      int k;
      wr(A_CTRL, 32'h0001_0007);
      wr(A_DIV, DIVV); wr(A_NUM, 32'd50 << 2); wr(A_DEN, 32'd100);
      wr(A_CMD, 32'h2);
      rd(A_STAT, v); chk("R4", "busy on retune", v, 32'h2);
      @(negedge clk); chk("R5", "hwsel cleared", outs(), 32'h0000_0007);
      @(negedge clk); chk("R5", "outen cleared", outs(), 32'h0000_0005);
      @(negedge clk); chk("R5", "pwrup cleared", outs(), 32'h0000_0004);
      @(negedge clk); chk("R5", "bypass cleared", outs(), 32'h0);
      chk("R5", "mfi not yet", mfi, 32'h0);
      @(negedge clk);
      chk("R5", "divider loaded", {mfi, rdv, odv}, {12'h0, 9'd162, 3'd1, 8'd6});
      chk("R5", "pwr low at load", pwr, 1'b0);
      chk("R3", "mfn loaded", mfn, 30'd50);
      chk("R3", "mfd loaded", mfd, 30'd100);
      chk("R11", "int mfi loaded", mfi_i, 9'd162);
      chk("R11", "int mfn/mfd zero", mfn_i | mfd_i, 30'd0);
      k = 0;
      for (int i = 1; i <= SN + 10; i++) begin
         @(negedge clk);
         if (pwr) begin k = i; break; end
      end
      chk("R6", "settle cycles", k, SN + 1);
      wr(A_CTRL, 32'h0); wr(A_DIV, 32'h0); wr(A_CMD, 32'h4); wr(A_NUM, 32'd7 << 2);
      chk("R12", "pwr held while busy", outs(), 32'h0000_0001);
      rd(A_CTRL, v); chk("R12", "ctrl rd unchanged", v, 32'h0000_0001);
      rd(A_DIV, v);  chk("R12", "div rd unchanged", v, DIVV);
      rd(A_NUM, v);  chk("R12", "num write accepted", v, 32'd7 << 2);
      chk("R12", "active mfn unchanged", mfn, 30'd50);
      lock = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R7", "outen after lock", outs(), 32'h0000_0003);
      rd(A_STAT, v); chk("R7", "idle after lock", v, 32'h1);
      lock = 1'b0;
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      int k;
      wr(A_CMD, 32'h2);
      bus_addr = A_STAT;
      k = 0;
      for (int i = 1; i <= SN + TN + 50; i++) begin
         @(negedge clk);
         if (!rdata[1]) begin k = i; break; end
      end
      chk("R8", "timeout duration", k, 6 + SN + TN);
      rd(A_STAT, v); chk("R8", "error flagged", v, 32'h4);
      chk("R8", "outen low pwr high", outs(), 32'h0000_0001);
   endtask

   task automatic t_prepare();
      logic [31:0] v;
      wr(A_CTRL, 32'h0001_0007);
      wr(A_CMD, 32'h4);
      rd(A_CTRL, v); chk("R10", "only pwr cleared", v, 32'h0001_0006);
      wr(A_CTRL, 32'h0);
      wr(A_CMD, 32'h1);
      rd(A_STAT, v); chk("R9", "busy, error cleared", v, 32'h2);
      @(negedge clk); chk("R9", "bypass first", outs(), 32'h0000_0004);
      @(negedge clk); chk("R9", "then power", outs(), 32'h0000_0005);
      @(negedge clk); chk("R9", "then outen", outs(), 32'h0000_0007);
      lock = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R9", "bypass released", outs(), 32'h0000_0003);
      rd(A_STAT, v); chk("R9", "idle after prepare", v, 32'h1);
      lock = 1'b0;
      wr(A_CTRL, 32'h1);
      wr(A_CMD, 32'h1);
      rd(A_STAT, v); chk("R9", "no busy when powered", v, 32'h0);
      @(negedge clk);
      rd(A_CTRL, v); chk("R9", "ctrl untouched when powered", v, 32'h1);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      int k;
      lock = 1'b1;
      wr(A_CMD, 32'h7);
      rd(A_STAT, v); chk("R4", "retune wins", v, 32'h3);
      bus_addr = A_STAT;
      k = 0;
      for (int i = 1; i <= SN + 50; i++) begin
         @(negedge clk);
         if (!rdata[1]) begin k = i; break; end
      end
      chk("R4", "retune completes", k != 0, 1'b1);
      chk("R7", "powered with output", outs(), 32'h0000_0003);
      chk("R3", "new mfn forwarded", mfn, 30'd7);
      chk("R11", "int mfn stays zero", mfn_i, 30'd0);
      lock = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL WD watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_retune_ok();
      t_timeout();
      t_prepare();
      t_priority();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule